// File: doc/BRIEF.md
# Board controller interrupt register block

This block is a small memory-mapped register file for a board controller. A host processor reaches it over a plain 32-bit register bus: an address, a write strobe, write data and read data. Eight of its words are simple storage for LED, switch and miscellaneous settings. Nothing inside the block acts on them. The remaining words form an interrupt aggregator and two PC-card socket status words.

Sixteen interrupt lines are sampled on every rising clock edge. When a line rises and its enable bit is set, the matching sticky pending bit is latched. The single host interrupt is high whenever an enabled pending bit exists. Writes to the enable and pending words pass through a fixed filter mask. Software clears pending bits by writing the pending word directly.

Lines 9 and 13 are also mirrored, inverted, into an active-low card-detect bit in socket words 0 and 1. In those socket words only the five lowest bits can be written.

Top module: `board_ctl_regs`

## Requirements
- R1: After reset the following hold: the eight storage words, the enable word and the pending word read 0; host_irq is 0; both socket words read 0x00000420, which is bit 10 ready and bit 5 card-detect high.
- R2: A write to a storage word at offsets 0x10, 0x14, 0x40, 0x60, 0x80, 0x84, 0x88 or 0x90 stores all 32 bits. A read at the same offset returns them.
- R3: A write to the enable word (offset 0xC0) or to the pending word (offset 0xD0) replaces it with the write data ANDed with 0x000FEEFF. Bits 8, 12 and 20 to 31 therefore always read 0.
- R4: A line counts as rising when it is sampled high at an edge after being sampled low at the previous edge. A rise sets that line's pending bit only if its enable bit was 1 before that edge. A rise while disabled is lost, and enabling the line later does not recover it.
- R5: When a rise sets a pending bit in the same cycle as a software write to the pending word, the bit ends up set.
- R6: host_irq is 1 exactly when the AND of the pending and enable words is nonzero. It follows any write to either word from the edge of that write.
- R7: Bit 5 of socket word 0 (offset 0xE0) reads the inverse of line 9. Bit 5 of socket word 1 (offset 0xE4) reads the inverse of line 13. In both cases the line value is the one sampled at the last edge.
- R8: A write to a socket word changes only its bits 4:0. Bit 10 stays 1, bit 5 keeps following its line, and all other bits stay 0.
- R9: A read at any offset not listed above returns 0. A write to such an offset changes no register.
- R10: A pending bit stays set after its line falls, until software writes the pending word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Byte offset of the register being read or written |
| bus_we | input | 1 | Write strobe for the addressed register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed register, combinational from bus_addr |
| irq_lines | input | 16 | Active-high interrupt inputs |
| host_irq | output | 1 | Interrupt request to the host |

## Verification
A write, a line sample, a pending latch and a card-detect change all take effect at the first rising edge that sees the stimulus. Their results, including host_irq, can be observed from just after that edge. Read data depends only on the address and the current register contents, so a read needs no clock.

The bench changes inputs at the falling edge and lets exactly one rising edge pass per step. It samples at the following falling edge, or a nanosecond after changing the address for a pure read. A bench model is advanced once per rising edge with the inputs present at that edge.

// File: rtl/bcr_pkg.sv
package bcr_pkg;

    localparam int DW         = 32;
    localparam int AW         = 8;
    localparam int NIRQ       = 16;
    localparam int NSTORE     = 8;
    localparam int NSLOT      = 2;
    localparam int SLOT_WBITS = 5;
    localparam int CD_BIT     = 5;
    localparam int RDY_BIT    = 10;
    localparam int IDXW       = $clog2(NSTORE);

    localparam logic [DW-1:0] IRQ_WMASK = 32'h000F_EEFF;

    typedef enum logic [2:0] {
        K_NONE,
        K_STORE,
        K_EN,
        K_PEND,
        K_SLOT
    } reg_kind_e;

    typedef struct packed {
        reg_kind_e       kind;
        logic [IDXW-1:0] idx;
    } reg_sel_t;

    function automatic reg_sel_t bcr_decode(input logic [AW-1:0] a);
        reg_sel_t s;
        s.kind = K_STORE;
        s.idx  = '0;
        case (a)
            8'h10: s.idx = IDXW'(0);
            8'h14: s.idx = IDXW'(1);
            8'h40: s.idx = IDXW'(2);
            8'h60: s.idx = IDXW'(3);
            8'h80: s.idx = IDXW'(4);
            8'h84: s.idx = IDXW'(5);
            8'h88: s.idx = IDXW'(6);
            8'h90: s.idx = IDXW'(7);
            8'hC0: s.kind = K_EN;
            8'hD0: s.kind = K_PEND;
            8'hE0: s.kind = K_SLOT;
            8'hE4: begin s.kind = K_SLOT; s.idx = IDXW'(1); end
            default: s.kind = K_NONE;
        endcase
        return s;
    endfunction

    function automatic logic [DW-1:0] slot_word(input logic [SLOT_WBITS-1:0] lo,
                                                input logic cd_n);
        logic [DW-1:0] w;
        w = '0;
        w[RDY_BIT] = 1'b1;
        w[CD_BIT]  = cd_n;
        w[SLOT_WBITS-1:0] = lo;
        return w;
    endfunction

endpackage

// File: rtl/bcr_store.sv
module bcr_store #(
    parameter int DW = 32,
    parameter int N  = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [N-1:0]         we,
    input  logic [DW-1:0]        wdata,
    output logic [N-1:0][DW-1:0] q
);
    for (genvar i = 0; i < N; i++) begin : g_word
        always_ff @(posedge clk) begin
            if (rst)        q[i] <= '0;
            else if (we[i]) q[i] <= wdata;
        end
    end
endmodule

// File: rtl/bcr_irq_agg.sv
module bcr_irq_agg #(
    parameter int            DW    = 32,
    parameter int            NIRQ  = 16,
    parameter logic [DW-1:0] WMASK = 32'h000F_EEFF
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NIRQ-1:0] irq_in,
    input  logic            en_we,
    input  logic            pend_we,
    input  logic [DW-1:0]   wdata,
    output logic [DW-1:0]   en_q,
    output logic [DW-1:0]   pend_q,
    output logic [NIRQ-1:0] in_q,
    output logic            irq_out
);
    logic [NIRQ-1:0] rise;
    logic [DW-1:0]   hw_set;
    logic [DW-1:0]   pend_base;

    assign rise      = irq_in & ~in_q;
    assign hw_set    = DW'(rise) & en_q;
    assign pend_base = pend_we ? (wdata & WMASK) : pend_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            in_q   <= '0;
            en_q   <= '0;
            pend_q <= '0;
        end else begin
            in_q   <= irq_in;
            if (en_we) en_q <= wdata & WMASK;
            pend_q <= pend_base | hw_set;
        end
    end

    assign irq_out = |(pend_q & en_q);

    // R3: filtered bits never become set
    a_r3_en_filtered: assert property (@(posedge clk) disable iff (rst)
        (en_q & ~WMASK) == '0);
    a_r3_pend_filtered: assert property (@(posedge clk) disable iff (rst)
        (pend_q & ~WMASK) == '0);

    // R4: without a software write, new pending bits only where enabled
    a_r4_masked_rise_lost: assert property (@(posedge clk) disable iff (rst)
        !pend_we |=> ((pend_q & ~$past(pend_q) & ~$past(en_q)) == '0));

    // R5: hardware set survives a simultaneous software write
    a_r5_hw_set_wins: assert property (@(posedge clk) disable iff (rst)
        pend_we |=> (($past(DW'(irq_in & ~in_q) & en_q) & ~pend_q) == '0));

    // R10: pending bits only clear through a software write
    a_r10_sticky: assert property (@(posedge clk) disable iff (rst)
        !pend_we |=> (($past(pend_q) & ~pend_q) == '0));
endmodule

// File: rtl/bcr_slot.sv
module bcr_slot #(
    parameter int DW    = 32,
    parameter int WBITS = 5
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [DW-1:0] wdata,
    input  logic          cd_src,
    output logic [DW-1:0] word
);
    logic [WBITS-1:0] lo;

    always_ff @(posedge clk) begin
        if (rst)     lo <= '0;
        else if (we) lo <= wdata[WBITS-1:0];
    end

    assign word = bcr_pkg::slot_word(lo, ~cd_src);

    // R8: writable field only moves on a write to this socket word
    a_r8_lo_hold: assert property (@(posedge clk) disable iff (rst)
        !we |=> $stable(word[WBITS-1:0]));
endmodule

// File: rtl/board_ctl_regs.sv
module board_ctl_regs
    import bcr_pkg::*;
#(
    parameter int SLOT0_SRC = 9,
    parameter int SLOT1_SRC = 13
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [AW-1:0]   bus_addr,
    input  logic            bus_we,
    input  logic [DW-1:0]   bus_wdata,
    output logic [DW-1:0]   bus_rdata,
    input  logic [NIRQ-1:0] irq_lines,
    output logic            host_irq
);
    localparam int SLOT_SRC [NSLOT] = '{SLOT0_SRC, SLOT1_SRC};

    reg_sel_t                  sel;
    logic [NSTORE-1:0]         store_we;
    logic [NSTORE-1:0][DW-1:0] store_q;
    logic [NSLOT-1:0]          slot_we;
    logic [NSLOT-1:0][DW-1:0]  slot_w;
    logic [DW-1:0]             en_q;
    logic [DW-1:0]             pend_q;
    logic [NIRQ-1:0]           in_q;

    assign sel = bcr_decode(bus_addr);

    always_comb begin
        store_we = '0;
        slot_we  = '0;
        if (bus_we && sel.kind == K_STORE) store_we[sel.idx] = 1'b1;
        if (bus_we && sel.kind == K_SLOT)  slot_we[sel.idx[0]] = 1'b1;
    end

    bcr_store #(.DW(DW), .N(NSTORE)) i_store (
        .clk   (clk),
        .rst   (rst),
        .we    (store_we),
        .wdata (bus_wdata),
        .q     (store_q)
    );

    bcr_irq_agg #(.DW(DW), .NIRQ(NIRQ), .WMASK(IRQ_WMASK)) i_irq (
        .clk     (clk),
        .rst     (rst),
        .irq_in  (irq_lines),
        .en_we   (bus_we && sel.kind == K_EN),
        .pend_we (bus_we && sel.kind == K_PEND),
        .wdata   (bus_wdata),
        .en_q    (en_q),
        .pend_q  (pend_q),
        .in_q    (in_q),
        .irq_out (host_irq)
    );

    for (genvar g = 0; g < NSLOT; g++) begin : g_slot
        bcr_slot #(.DW(DW), .WBITS(SLOT_WBITS)) i_slot (
            .clk    (clk),
            .rst    (rst),
            .we     (slot_we[g]),
            .wdata  (bus_wdata),
            .cd_src (in_q[SLOT_SRC[g]]),
            .word   (slot_w[g])
        );

        // R7: card-detect bit is the inverted line from one edge earlier
        a_r7_cd_follows: assert property (@(posedge clk) disable iff (rst)
            !rst |=> (slot_w[g][CD_BIT] == !$past(irq_lines[SLOT_SRC[g]])));
    end

    always_comb begin
        case (sel.kind)
            K_STORE: bus_rdata = store_q[sel.idx];
            K_EN:    bus_rdata = en_q;
            K_PEND:  bus_rdata = pend_q;
            K_SLOT:  bus_rdata = slot_w[sel.idx[0]];
            default: bus_rdata = '0;
        endcase
    end

    // R6: after an enable write the request reflects the new enable word
    a_r6_irq_after_en_write: assert property (@(posedge clk) disable iff (rst)
        (bus_we && sel.kind == K_EN) |=>
            (host_irq == |(pend_q & $past(bus_wdata) & IRQ_WMASK)));
endmodule

// File: tb/test_board_ctl_regs.sv
module test_board_ctl_regs;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [15:0] irq_lines = '0;
    logic        host_irq;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    board_ctl_regs i_board_ctl_regs (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_lines(irq_lines), .host_irq(host_irq)
    );

    // bench model, built from the requirements
    localparam logic [31:0] FILT = 32'h000F_EEFF;
    logic [31:0] m_store [8];
    logic [31:0] m_en, m_pend;
    logic [15:0] m_prev;
    logic [4:0]  m_lo [2];
    logic [15:0] cur_in = '0;

    function automatic int store_index(input logic [7:0] a);
        case (a)
            8'h10: return 0; 8'h14: return 1; 8'h40: return 2; 8'h60: return 3;
            8'h80: return 4; 8'h84: return 5; 8'h88: return 6; 8'h90: return 7;
            default: return -1;
        endcase
    endfunction

    function automatic logic [31:0] exp_read(input logic [7:0] a);
        int si;
        si = store_index(a);
        if (si >= 0) return m_store[si];
        case (a)
            8'hC0: return m_en;
            8'hD0: return m_pend;
            8'hE0: return 32'h400 | (m_prev[9]  ? 32'h0 : 32'h20) | 32'(m_lo[0]);
            8'hE4: return 32'h400 | (m_prev[13] ? 32'h0 : 32'h20) | 32'(m_lo[1]);
            default: return 32'h0;
        endcase
    endfunction

    function automatic logic exp_irq();
        return |(m_en & m_pend);
    endfunction

    function automatic string tag_of(input logic [7:0] a);
        if (store_index(a) >= 0) return "R2";
        case (a)
            8'hC0, 8'hD0: return "R3";
            8'hE0, 8'hE4: return "R8";
            default: return "R9";
        endcase
    endfunction

    task automatic model_reset();
        for (int i = 0; i < 8; i++) m_store[i] = '0;
        m_en = '0; m_pend = '0; m_prev = '0; m_lo[0] = '0; m_lo[1] = '0;
    endtask

    task automatic model_clock(input logic we, input logic [7:0] a,
                               input logic [31:0] d, input logic [15:0] in);
        logic [31:0] set, np;
        int si;
        set = {16'h0, in & ~m_prev} & m_en;
        np  = m_pend;
        si  = store_index(a);
        if (we) begin
            if (si >= 0) m_store[si] = d;
            case (a)
                8'hC0: m_en = d & FILT;
                8'hD0: np   = d & FILT;
                8'hE0: m_lo[0] = d[4:0];
                8'hE4: m_lo[1] = d[4:0];
                default: ;
            endcase
        end
        m_pend = np | set;
        m_prev = in;
    endtask

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    // called at a falling edge; one rising edge passes; returns at the next falling edge
    task automatic step(input logic we, input logic [7:0] a, input logic [31:0] d);
        bus_we = we; bus_addr = a; bus_wdata = d; irq_lines = cur_in;
        @(posedge clk);
        model_clock(we, a, d, cur_in);
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic check_read(input string tag, input logic [7:0] a);
        bus_we = 1'b0; bus_addr = a;
        #1;
        check(tag, bus_rdata, exp_read(a));
    endtask

    task automatic check_irq(input string tag);
        check(tag, {31'h0, host_irq}, {31'h0, exp_irq()});
    endtask

    localparam logic [7:0] ADDRS [18] = '{8'h10, 8'h14, 8'h40, 8'h60, 8'h80, 8'h84,
        8'h88, 8'h90, 8'hC0, 8'hD0, 8'hE0, 8'hE4, 8'h00, 8'h44, 8'hE8, 8'hF0, 8'hC4, 8'h8C};

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        for (int i = 0; i < 12; i++) check_read("R1", ADDRS[i]);
        check_read("R1", 8'hE0);
        check("R1", bus_rdata, 32'h0000_0420);
        check("R1", {31'h0, host_irq}, 32'h0);

        // R2 storage words
        for (int i = 0; i < 8; i++) step(1'b1, ADDRS[i], 32'hA5C3_0000 + 32'(i * 32'h1111));
        for (int i = 0; i < 8; i++) check_read("R2", ADDRS[i]);

        // R3 filtered writes, R6 request follows
        step(1'b1, 8'hC0, 32'hFFFF_FFFF);
        check_read("R3", 8'hC0);
        check("R3", bus_rdata, 32'h000F_EEFF);
        step(1'b1, 8'hD0, 32'hFFFF_FFFF);
        check_read("R3", 8'hD0);
        check("R3", bus_rdata, 32'h000F_EEFF);
        check("R6", {31'h0, host_irq}, 32'h1);
        step(1'b1, 8'hD0, 32'h0);
        check("R6", {31'h0, host_irq}, 32'h0);
        step(1'b1, 8'hC0, 32'h0000_0108);   // bit 8 is filtered away

        // R4 enabled rise latches, disabled rise lost
        cur_in = 16'h0118;                   // lines 3, 4, 8
        step(1'b0, 8'h00, 32'h0);
        check_read("R4", 8'hD0);
        check("R4", bus_rdata, 32'h0000_0008);
        check_irq("R4");
        step(1'b1, 8'hC0, 32'h0000_0018);
        check_read("R4", 8'hD0);
        check("R4", bus_rdata, 32'h0000_0008);
        // R10 sticky after fall
        cur_in = 16'h0000;
        step(1'b0, 8'h00, 32'h0);
        check_read("R10", 8'hD0);
        check("R10", bus_rdata, 32'h0000_0008);
        // R9 unmapped write and read
        step(1'b1, 8'h44, 32'hFFFF_FFFF);
        step(1'b1, 8'hF0, 32'hFFFF_FFFF);
        check_read("R9", 8'h44);
        check("R9", bus_rdata, 32'h0);
        for (int i = 0; i < 12; i++) check_read("R9", ADDRS[i]);

        // R5 hardware set against software clear
        step(1'b1, 8'hC0, 32'h0000_0004);
        cur_in = 16'h0004;
        step(1'b1, 8'hD0, 32'h0);
        check_read("R5", 8'hD0);
        check("R5", bus_rdata, 32'h0000_0004);
        // R6 enable gating of the request
        step(1'b1, 8'hC0, 32'h0);
        check("R6", {31'h0, host_irq}, 32'h0);
        step(1'b1, 8'hC0, 32'h0000_0004);
        check("R6", {31'h0, host_irq}, 32'h1);

        // R7 card-detect mirrors
        cur_in = 16'h0200;
        step(1'b0, 8'h00, 32'h0);
        check_read("R7", 8'hE0);
        check("R7", bus_rdata, 32'h0000_0400);
        check_read("R7", 8'hE4);
        check("R7", bus_rdata, 32'h0000_0420);
        cur_in = 16'h2000;
        step(1'b0, 8'h00, 32'h0);
        check_read("R7", 8'hE0);
        check("R7", bus_rdata, 32'h0000_0420);
        check_read("R7", 8'hE4);
        check("R7", bus_rdata, 32'h0000_0400);

        // R8 only low five bits writable
        cur_in = 16'h0000;
        step(1'b1, 8'hE0, 32'hFFFF_FFFF);
        check_read("R8", 8'hE0);
        check("R8", bus_rdata, 32'h0000_043F);
        step(1'b1, 8'hE4, 32'h0000_0000);
        check_read("R8", 8'hE4);
        check("R8", bus_rdata, 32'h0000_0420);

        // random traffic against the model
        for (int n = 0; n < 2000; n++) begin
            logic [7:0]  a;
            logic [31:0] d;
            logic        we;
            if ($urandom % 3 == 0) cur_in = cur_in ^ (16'h1 << ($urandom % 16));
            a  = ($urandom % 8 == 0) ? 8'($urandom) : ADDRS[$urandom % 18];
            we = ($urandom % 3 == 0);
            d  = $urandom;
            if (a == 8'hD0 && ($urandom % 2 == 0)) d = 32'h0;
            step(we, a, d);
            check_irq("R6");
            a = ADDRS[$urandom % 18];
            check_read(tag_of(a), a);
        end

        summary();
        $finish;
    end
endmodule